// File: doc/BRIEF.md
# Tuner Synthesizer Control Slave (two-wire serial)

This block is a two-wire serial slave that holds the programming word of a tuner frequency synthesizer. A host writes a 10-bit main count, a 5-bit swallow count, loop control flags, an optional reference-ratio field and four band-select lines. It reads back a status byte that carries a power-up flag and the lock flag. SCL and SDA are oversampled by the system clock, and SDA is driven through an open-drain enable.

Written bytes are decoded by their position and their most significant bit. If a byte arrives while the slave expects a new group and its MSB is 0, it opens the divider pair. If its MSB is 1, it is a control byte, and the band byte follows it. Accepted bytes are first held in a staging copy. The outputs change only when a STOP ends the transaction.

Three level inputs shape the decoding. One strap swaps the two upper band bits. One selects whether the control byte may set the reference ratio. One selects the narrow divider, which holds the top main-count bit at zero.

Top module: `tuner_pll_i2c`

## Requirements
- R1: The slave answers only the 7-bit address {5'b11000, addr_sel}, with bit 0 of the address byte as R/W (0 = write, 1 = read). After any other address it never pulls SDA low, and it takes no byte until the next START.
- R2: After a matching address, the slave pulls SDA low in the acknowledge slot of the address byte and of every byte it receives.
- R3: A byte with bit7 = 0 that arrives where a new group is expected is divider byte 1, and bits 6..0 give main count bits 9..3. The byte after it is divider byte 2: bits 7..5 give main count bits 2..0, and bits 4..0 give the swallow count.
- R4: A byte with bit7 = 1 that arrives where a new group is expected is the control byte: bit6 = cp_high, bit5 = test_en, bit4 = cp_off, bit0 = vari_off, and bit3 is ignored. The byte after it is the band byte.
- R5: Control bits 2..1 load ref_ratio (bit2 to ref_ratio[1]) only while ref_mode = 1. When ref_mode = 0, ref_ratio keeps its value.
- R6: With swap_band = 0, the band byte maps bit3 to band_uhf, bit2 to band_trap, bit1 to band_high and bit0 to band_low. Each output is active-high, and bits 7..4 are ignored.
- R7: With swap_band = 1, bit3 drives band_trap and bit2 drives band_uhf. Bits 1..0 keep the R6 mapping.
- R8: While narrow_div = 1, a committed divider write leaves main_cnt[9] at 0 whatever the written bit.
- R9: Outputs change only on STOP. A START that comes before the STOP discards the bytes staged so far.
- R10: A read returns {pr, lock_i, 1, 1, 1, 0, 0, 0}, MSB first. A master acknowledge makes the slave send the status byte again, and a master not-acknowledge ends the read.
- R11: The pr bit is 1 after reset. It clears once the first status byte has been sent completely.
- R12: During and after reset, all configuration outputs are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 2 | Low two bits of the slave address |
| swap_band | input | 1 | Swap the uhf and trap positions of the band byte |
| ref_mode | input | 1 | Let control bits 2..1 set the reference ratio |
| narrow_div | input | 1 | Narrow divider: main count bit 9 held at 0 |
| lock_i | input | 1 | Synthesizer lock flag for the status byte |
| main_cnt | output | 10 | Main divider count |
| swallow_cnt | output | 5 | Swallow counter value |
| cp_high | output | 1 | High charge-pump current |
| test_en | output | 1 | Test mode flag |
| cp_off | output | 1 | Charge pump disabled |
| vari_off | output | 1 | Varicap drive disabled |
| ref_ratio | output | 2 | Reference divider selection |
| band_low | output | 1 | Low VHF band supply on |
| band_high | output | 1 | High VHF band supply on |
| band_trap | output | 1 | FM trap on |
| band_uhf | output | 1 | UHF band supply on |

## Verification
The assertions assume that SDA changes only while SCL is low, except at START and STOP. They also assume that every SCL level lasts many system clocks, longer than the synchronizer plus a few cycles. The narrow and reference-mode checks further assume those pins hold steady around the STOP that commits a write. The bench keeps to all of this. Its master moves each line only at a falling system-clock edge, holds every quarter of an SCL bit for ten clocks, and changes the level pins only between transactions.

// File: rtl/tpi_pkg.sv
`timescale 1ns/1ps
package tpi_pkg;
  localparam int MAIN_W = 10;
  localparam int SWAL_W = 5;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR, LS_RX, LS_ACK, LS_TX, LS_MACK, LS_IGN
  } link_state_e;

  typedef enum logic [1:0] {
    NX_CLASS, NX_DIV2, NX_BAND
  } next_byte_e;
endpackage

// File: rtl/tpi_filter.sv
`timescale 1ns/1ps
module tpi_filter #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_q     = scl_sr[STAGES-1];
  assign sda_q     = sda_sr[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign bus_start = scl_q & scl_d & sda_d & ~sda_q;
  assign bus_stop  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/tpi_link.sv
`timescale 1ns/1ps
module tpi_link
  import tpi_pkg::*;
#(
  parameter logic [4:0] DEV_ID = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              stat_done
);
  link_state_e       state;
  logic [2:0]        bit_cnt;
  logic              full, rw, more;
  logic [BYTE_W-1:0] sh, tx_sh;

  always_ff @(posedge clk) begin
    wr_stb    <= 1'b0;
    start_evt <= 1'b0;
    stop_evt  <= 1'b0;
    stat_done <= 1'b0;
    if (rst) begin
      state   <= LS_IDLE;
      sda_oe  <= 1'b0;
      bit_cnt <= '0;
      full    <= 1'b0;
      rw      <= 1'b0;
      more    <= 1'b0;
      sh      <= '0;
      tx_sh   <= '0;
      wr_byte <= '0;
    end else if (bus_start) begin
      state     <= LS_ADDR;
      bit_cnt   <= '0;
      full      <= 1'b0;
      sda_oe    <= 1'b0;
      start_evt <= 1'b1;
    end else if (bus_stop) begin
      state    <= LS_IDLE;
      sda_oe   <= 1'b0;
      stop_evt <= 1'b1;
    end else begin
      case (state)
        LS_ADDR, LS_RX: begin
          if (scl_rise && !full) begin
            sh      <= {sh[BYTE_W-2:0], sda_q};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full    <= 1'b0;
            bit_cnt <= '0;
            if (state == LS_ADDR) begin
              if (sh[7:1] == {DEV_ID, addr_sel}) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                state  <= LS_ACK;
              end else begin
                state <= LS_IGN;
              end
            end else begin
              sda_oe  <= 1'b1;
              wr_stb  <= 1'b1;
              wr_byte <= sh;
              state   <= LS_ACK;
            end
          end
        end
        LS_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              tx_sh  <= status_byte;
              sda_oe <= ~status_byte[7];
              state  <= LS_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= LS_RX;
            end
          end
        end
        LS_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= LS_MACK;
            end else begin
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        LS_MACK: begin
          if (scl_rise) begin
            more      <= ~sda_q;
            stat_done <= 1'b1;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (more) begin
              tx_sh  <= status_byte;
              sda_oe <= ~status_byte[7];
              state  <= LS_TX;
            end else begin
              state <= LS_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  ign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state == LS_IGN |-> !sda_oe);
  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    state == LS_IDLE |-> !sda_oe);
  // R2
  ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
    state == LS_ACK |-> sda_oe);
  // R10
  mack_release_chk: assert property (@(posedge clk) disable iff (rst)
    state == LS_MACK |-> !sda_oe);
endmodule

// File: rtl/tpi_regfile.sv
`timescale 1ns/1ps
module tpi_regfile
  import tpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              stat_done,
  input  logic              swap_band,
  input  logic              ref_mode,
  input  logic              narrow_div,
  input  logic              lock_i,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swallow_cnt,
  output logic              cp_high,
  output logic              test_en,
  output logic              cp_off,
  output logic              vari_off,
  output logic [1:0]        ref_ratio,
  output logic [3:0]        band,
  output logic [BYTE_W-1:0] status_byte
);
  localparam int HI_W = MAIN_W - 3;

  next_byte_e      nxt;
  logic [HI_W-1:0] stg_div1;
  logic [7:0]      stg_div2;
  logic [6:0]      stg_ctrl;
  logic [3:0]      stg_band;
  logic [3:0]      dirty;
  logic            pr;
  logic            unused_ctrl_bit;

  assign unused_ctrl_bit = stg_ctrl[3];
  assign status_byte     = {pr, lock_i, 3'b111, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt         <= NX_CLASS;
      stg_div1    <= '0;
      stg_div2    <= '0;
      stg_ctrl    <= '0;
      stg_band    <= '0;
      dirty       <= '0;
      pr          <= 1'b1;
      main_cnt    <= '0;
      swallow_cnt <= '0;
      cp_high     <= 1'b0;
      test_en     <= 1'b0;
      cp_off      <= 1'b0;
      vari_off    <= 1'b0;
      ref_ratio   <= '0;
      band        <= '0;
    end else begin
      if (stat_done) pr <= 1'b0;
      if (start_evt) begin
        nxt   <= NX_CLASS;
        dirty <= '0;
      end else if (stop_evt) begin
        dirty <= '0;
        nxt   <= NX_CLASS;
        if (dirty[0]) main_cnt[MAIN_W-1:3] <= {stg_div1[HI_W-1] & ~narrow_div, stg_div1[HI_W-2:0]};
        if (dirty[1]) begin
          main_cnt[2:0] <= stg_div2[7:5];
          swallow_cnt   <= stg_div2[4:0];
        end
        if (dirty[2]) begin
          cp_high  <= stg_ctrl[6];
          test_en  <= stg_ctrl[5];
          cp_off   <= stg_ctrl[4];
          vari_off <= stg_ctrl[0];
          if (ref_mode) ref_ratio <= stg_ctrl[2:1];
        end
        if (dirty[3]) begin
          band[1:0] <= stg_band[1:0];
          band[3]   <= swap_band ? stg_band[2] : stg_band[3];
          band[2]   <= swap_band ? stg_band[3] : stg_band[2];
        end
      end else if (wr_stb) begin
        case (nxt)
          NX_DIV2: begin
            stg_div2 <= wr_byte;
            dirty[1] <= 1'b1;
            nxt      <= NX_CLASS;
          end
          NX_BAND: begin
            stg_band <= wr_byte[3:0];
            dirty[3] <= 1'b1;
            nxt      <= NX_CLASS;
          end
          default: begin
            if (!wr_byte[7]) begin
              stg_div1 <= wr_byte[HI_W-1:0];
              dirty[0] <= 1'b1;
              nxt      <= NX_DIV2;
            end else begin
              stg_ctrl <= wr_byte[6:0];
              dirty[2] <= 1'b1;
              nxt      <= NX_BAND;
            end
          end
        endcase
      end
    end
  end

  // R9
  hold_until_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_evt |=> $stable({main_cnt, swallow_cnt, cp_high, test_en, cp_off, vari_off, ref_ratio, band}));
  // R8
  narrow_m9_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && narrow_div && dirty[0]) |=> !main_cnt[MAIN_W-1]);
  // R5
  ref_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !ref_mode) |=> $stable(ref_ratio));
  // R11
  pr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pr) |-> $past(stat_done));
endmodule

// File: rtl/tuner_pll_i2c.sv
`timescale 1ns/1ps
module tuner_pll_i2c
  import tpi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_ID      = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              swap_band,
  input  logic              ref_mode,
  input  logic              narrow_div,
  input  logic              lock_i,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swallow_cnt,
  output logic              cp_high,
  output logic              test_en,
  output logic              cp_off,
  output logic              vari_off,
  output logic [1:0]        ref_ratio,
  output logic              band_low,
  output logic              band_high,
  output logic              band_trap,
  output logic              band_uhf
);
  logic sda_q, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_stb, start_evt, stop_evt, stat_done;
  logic [BYTE_W-1:0] wr_byte, status_byte;
  logic [3:0] band;

  tpi_filter #(.STAGES(SYNC_STAGES)) u_filter (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  tpi_link #(.DEV_ID(DEV_ID)) u_link (
    .clk(clk), .rst(rst), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .addr_sel(addr_sel),
    .status_byte(status_byte), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .start_evt(start_evt), .stop_evt(stop_evt), .stat_done(stat_done)
  );

  tpi_regfile u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .start_evt(start_evt), .stop_evt(stop_evt), .stat_done(stat_done),
    .swap_band(swap_band), .ref_mode(ref_mode), .narrow_div(narrow_div), .lock_i(lock_i),
    .main_cnt(main_cnt), .swallow_cnt(swallow_cnt), .cp_high(cp_high), .test_en(test_en),
    .cp_off(cp_off), .vari_off(vari_off), .ref_ratio(ref_ratio), .band(band),
    .status_byte(status_byte)
  );

  assign band_low  = band[0];
  assign band_high = band[1];
  assign band_trap = band[2];
  assign band_uhf  = band[3];
endmodule

// File: tb/tuner_pll_i2c_tb.sv
`timescale 1ns/1ps
module tuner_pll_i2c_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  logic [1:0] addr_sel = 2'b10;
  logic swap = 1'b0, refm = 1'b0, narrow = 1'b0, lock = 1'b0;
  logic [9:0] main_cnt;
  logic [4:0] swallow_cnt;
  logic cp_high, test_en, cp_off, vari_off;
  logic [1:0] ref_ratio;
  logic band_low, band_high, band_trap, band_uhf;

  tuner_pll_i2c u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .swap_band(swap), .ref_mode(refm), .narrow_div(narrow),
    .lock_i(lock), .main_cnt(main_cnt), .swallow_cnt(swallow_cnt), .cp_high(cp_high),
    .test_en(test_en), .cp_off(cp_off), .vari_off(vari_off), .ref_ratio(ref_ratio),
    .band_low(band_low), .band_high(band_high), .band_trap(band_trap), .band_uhf(band_uhf)
  );

  int errs = 0, checks = 0;
  logic [24:0] exp_q[$];
  string tag_q[$];

  // Bench model of committed state
  logic [9:0] m_main = '0;
  logic [4:0] m_swl = '0;
  logic m_cp = 0, m_t = 0, m_cd = 0, m_os = 0;
  logic [1:0] m_ref = '0;
  logic [3:0] m_band = '0; // {uhf, trap, high, low}

  logic [24:0] obs;
  assign obs = {main_cnt, swallow_cnt, cp_high, test_en, cp_off, vari_off, ref_ratio,
                band_uhf, band_trap, band_high, band_low};

  function automatic logic [3:0] mk_band(input logic [3:0] nib, input logic sw);
    return sw ? {nib[2], nib[3], nib[1], nib[0]} : nib;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag);
    exp_q.push_back({m_main, m_swl, m_cp, m_t, m_cd, m_os, m_ref, m_band});
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      #1;
      chk(tag_q.pop_front(), {7'd0, obs}, {7'd0, exp_q.pop_front()});
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = ~sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0; wt(Q);
    end
    sda_m = ~mack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q); sda_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    wt(5); rst = 1'b0; wt(5);
    // R12 reset state
    push("R12 reset outputs");
    chk("R12 sda released", {31'd0, sda_oe}, 32'd0);
    wt(4);

    // R10 R11 status read after reset
    bus_start(); send_byte(8'hC5, ack); chk("R1 read address ack", {31'd0, ack}, 32'd1);
    read_byte(1'b0, d); chk("R10 R11 status after reset", {24'd0, d}, 32'hB8);
    bus_stop(); wt(8);
    lock = 1'b1;
    bus_start(); send_byte(8'hC5, ack);
    read_byte(1'b1, d); chk("R11 pr cleared, lock set", {24'd0, d}, 32'h78);
    read_byte(1'b0, d); chk("R10 repeated status byte", {24'd0, d}, 32'h78);
    bus_stop(); wt(8); lock = 1'b0;

    // R3 R4 R5 R6: full write, ref mode off
    bus_start(); send_byte(8'hC4, ack); chk("R1 write address ack", {31'd0, ack}, 32'd1);
    send_byte(8'h55, ack); chk("R2 div1 ack", {31'd0, ack}, 32'd1);
    send_byte(8'hB3, ack); chk("R2 div2 ack", {31'd0, ack}, 32'd1);
    send_byte(8'hD7, ack); chk("R2 ctrl ack", {31'd0, ack}, 32'd1);
    send_byte(8'hF5, ack); chk("R2 band ack", {31'd0, ack}, 32'd1);
    wt(4); push("R9 no update before STOP"); wt(4);
    bus_stop(); wt(10);
    m_main = {7'h55, 3'b101}; m_swl = 5'b10011;
    m_cp = 1; m_t = 0; m_cd = 1; m_os = 1;
    m_band = mk_band(4'h5, 1'b0);
    push("R3 R4 R5 R6 committed write"); wt(4);

    // R5 R7: ref mode on, strap swapped, control first
    refm = 1'b1; swap = 1'b1; wt(4);
    bus_start(); send_byte(8'hC4, ack); send_byte(8'h82, ack); send_byte(8'h0A, ack);
    bus_stop(); wt(10);
    m_cp = 0; m_t = 0; m_cd = 0; m_os = 0; m_ref = 2'b01;
    m_band = mk_band(4'hA, 1'b1);
    push("R5 R7 ref field and swapped band"); wt(4);

    // R8: narrow divider
    narrow = 1'b1; wt(4);
    bus_start(); send_byte(8'hC4, ack); send_byte(8'h7F, ack); send_byte(8'h00, ack);
    bus_stop(); wt(10);
    m_main = 10'h1F8; m_swl = 5'd0;
    push("R8 main bit 9 held low"); wt(4);
    narrow = 1'b0; wt(4);

    // R9: repeated START discards staged bytes
    bus_start(); send_byte(8'hC4, ack); send_byte(8'h01, ack); send_byte(8'h01, ack);
    bus_start(); bus_stop(); wt(10);
    push("R9 aborted write discarded"); wt(4);

    // R1: foreign address ignored
    bus_start(); send_byte(8'hC0, ack); chk("R1 foreign address no ack", {31'd0, ack}, 32'd0);
    send_byte(8'h00, ack); chk("R1 ignored byte no ack", {31'd0, ack}, 32'd0);
    send_byte(8'h00, ack);
    bus_stop(); wt(10);
    push("R1 foreign write no effect"); wt(4);

    // R6: default mapping, upper nibble ignored
    swap = 1'b0; wt(4);
    bus_start(); send_byte(8'hC4, ack); send_byte(8'h80, ack); send_byte(8'hF8, ack);
    bus_stop(); wt(10);
    m_cp = 0; m_t = 0; m_cd = 0; m_os = 0; m_ref = 2'b00;
    m_band = 4'b1000;
    push("R6 default band order, upper nibble ignored"); wt(4);

    // R10: status with lock low after writes
    bus_start(); send_byte(8'hC5, ack);
    read_byte(1'b0, d); chk("R10 status lock low", {24'd0, d}, 32'h38);
    bus_stop(); wt(10);
    chk("R12 sda released at end", {31'd0, sda_oe}, 32'd0);

    wait (exp_q.size() == 0);
    wt(4);
    finish_run();
  end
endmodule